// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block sits between a CPU core and the pins of an external memory bus whose low byte is shared between address and data. The CPU issues one request at a time: a code fetch or a data access, the 16-bit address, a write flag and write data. The block turns the request into a fixed bus cycle of twelve oscillator clocks, one machine cycle. It then pulses a done signal with the byte that was read. Code space and data space are separate 64 KB spaces. The kind of request picks the space, not the address.

Code fetches below 1000H can be served by an on-chip 4 KB ROM instead of the bus. This happens only while the external-access input is high. The block addresses that ROM through its own port and leaves every bus strobe quiet, but it keeps the same twelve-clock rhythm, so the CPU sees identical timing either way. A data access always goes to the bus. A code fetch goes to the bus when its address is 1000H or above, or when the external-access input is low.

Clock k of an access (k = 0..11) is the k-th clock period after the rising edge that accepted the request.

Top module: `ext_bus_seq`

## Requirements
- R1: After reset, and while idle, the latch strobe is low, all three active-low strobes (program read, data read, data write) are high, the low byte is not driven, the high byte reads 00H and done is low.
- R2: A request taken while idle produces exactly one done pulse, one clock wide, on clock 11. The block then returns to idle on the next clock.
- R3: In an external access the latch strobe is high on clocks 0 and 1 only. The low byte drives address bits 7..0 on clocks 0 to 2. The high byte carries address bits 15..8 on clocks 0 to 11.
- R4: An external code fetch drives the program read strobe low on clocks 3 to 10 and on no other clock. The data strobes stay high, and a write flag given with a code fetch is ignored.
- R5: An external data read drives the data read strobe low on clocks 3 to 10 and releases the low byte from clock 3. Done returns the low byte as it stood on clock 10.
- R6: An external data write drives the data write strobe low on clocks 3 to 10. The low byte carries the write data on each of those clocks.
- R7: A code fetch below 1000H with the external-access input high is internal. No latch strobe, no bus strobe and no low-byte drive appear, and the high byte stays 00H. The ROM address port carries address bits 11..0, and done returns the ROM byte as it stood on clock 10.
- R8: With the external-access input low, every code fetch is external, including addresses 0000H to 0FFFH.
- R9: With the external-access input high, code fetches from 1000H to FFFFH are external.
- R10: Data accesses are external at every address, including 0000H to 0FFFH.
- R11: A request raised during an access is ignored. The bus outputs keep following the first access, and no extra access or done pulse follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when idle |
| reqCode | input | 1 | 1 = code fetch, 0 = data access |
| reqWrite | input | 1 | 1 = data write (ignored for code) |
| reqAddr | input | 16 | Access address |
| reqWdata | input | 8 | Write data |
| extAccessN | input | 1 | High lets the internal ROM serve code below 1000H |
| romAddr | output | 12 | Internal ROM address |
| romRdata | input | 8 | Internal ROM data |
| busLowOut | output | 8 | Low bus byte, outgoing value |
| busLowOe | output | 1 | Low bus byte drive enable |
| busLowIn | input | 8 | Low bus byte, incoming value |
| busHigh | output | 8 | High address byte |
| latchStrobe | output | 1 | Address latch strobe, active high |
| progStrobeN | output | 1 | Program read strobe, active low |
| rdStrobeN | output | 1 | Data read strobe, active low |
| wrStrobeN | output | 1 | Data write strobe, active low |
| doneValid | output | 1 | One-clock completion pulse |
| doneData | output | 8 | Read byte, valid with doneValid |

## Verification
All bus outputs are decoded from the registered phase count, so each one changes just after a rising edge. Read data is registered at the edge that ends clock 10 and shows on clock 11, together with done. The bench raises a request for one clock from a falling edge and then samples every output at the falling edge of each clock 0 to 11. It compares each sample with the value the requirements give for that clock, then samples once more on the idle clock that follows. An external memory model latches the low byte when the latch strobe falls and answers read strobes with a byte computed from the full address, so the returned data proves the address timing as well.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  // Strobes from the sequencing control to the datapath, one set per clock.
  typedef struct packed {
    logic capture;   // take the request this edge
    logic active;    // an access is in progress
    logic latchOn;   // address latch window
    logic addrOut;   // low byte carries address
    logic strobeOn;  // read/write strobe window
    logic sample;    // register read data this edge
    logic done;      // last clock of the access
  } xbusCtl_t;
endpackage

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int CLKS_PER_MC = 12,
  parameter int LATCH_END   = 1,
  parameter int DATA_START  = 3,
  parameter int STROBE_END  = 10,
  parameter int SAMPLE_AT   = 10
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  output xbusCtl_t ctl
);
  localparam int PH_W = $clog2(CLKS_PER_MC);
  localparam logic [PH_W-1:0] PH_LAST   = PH_W'(CLKS_PER_MC - 1);
  localparam logic [PH_W-1:0] PH_LATCH  = PH_W'(LATCH_END);
  localparam logic [PH_W-1:0] PH_DATA   = PH_W'(DATA_START);
  localparam logic [PH_W-1:0] PH_STREND = PH_W'(STROBE_END);
  localparam logic [PH_W-1:0] PH_SAMPLE = PH_W'(SAMPLE_AT);

  logic            busy;
  logic [PH_W-1:0] phase;
  logic            accept;

  assign accept = reqValid && !busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy  <= 1'b0;
      phase <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      phase <= '0;
    end else if (busy) begin
      if (phase == PH_LAST) begin
        busy  <= 1'b0;
        phase <= '0;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.capture  = accept;
    ctl.active   = busy;
    ctl.latchOn  = busy && (phase <= PH_LATCH);
    ctl.addrOut  = busy && (phase < PH_DATA);
    ctl.strobeOn = busy && (phase >= PH_DATA) && (phase <= PH_STREND);
    ctl.sample   = busy && (phase == PH_SAMPLE);
    ctl.done     = busy && (phase == PH_LAST);
  end
endmodule

// File: rtl/xbus_dp.sv
module xbus_dp
  import xbus_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int ROM_ADDR_W = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  xbusCtl_t              ctl,
  input  logic                  reqCode,
  input  logic                  reqWrite,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [DATA_W-1:0]     reqWdata,
  input  logic                  extAccessN,
  output logic [ROM_ADDR_W-1:0] romAddr,
  input  logic [DATA_W-1:0]     romRdata,
  output logic [DATA_W-1:0]     busLowOut,
  output logic                  busLowOe,
  input  logic [DATA_W-1:0]     busLowIn,
  output logic [ADDR_W-DATA_W-1:0] busHigh,
  output logic                  latchStrobe,
  output logic                  progStrobeN,
  output logic                  rdStrobeN,
  output logic                  wrStrobeN,
  output logic                  doneValid,
  output logic [DATA_W-1:0]     doneData
);
  localparam int HI_W = ADDR_W - DATA_W;
  localparam int TOP_W = ADDR_W - ROM_ADDR_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic              codeQ;
  logic              writeQ;
  logic              extQ;
  logic              inRom;

  // Code below the ROM top is internal only while the pin allows it.
  assign inRom = (reqAddr[ADDR_W-1:ROM_ADDR_W] == TOP_W'(0));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      codeQ  <= 1'b0;
      writeQ <= 1'b0;
      extQ   <= 1'b0;
    end else if (ctl.capture) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      codeQ  <= reqCode;
      writeQ <= reqWrite && !reqCode;
      extQ   <= !(reqCode && extAccessN && inRom);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdataQ <= '0;
    end else if (ctl.sample) begin
      rdataQ <= extQ ? busLowIn : romRdata;
    end
  end

  logic busCycle;
  logic wrDrive;
  assign busCycle = ctl.active && extQ;
  assign wrDrive  = extQ && writeQ && ctl.strobeOn;

  always_comb begin
    latchStrobe = extQ && ctl.latchOn;
    busLowOe    = (extQ && ctl.addrOut) || wrDrive;
    if (extQ && ctl.addrOut)  busLowOut = addrQ[DATA_W-1:0];
    else if (wrDrive)         busLowOut = wdataQ;
    else                      busLowOut = '0;
    busHigh     = busCycle ? addrQ[ADDR_W-1:DATA_W] : HI_W'(0);
    progStrobeN = !(extQ && ctl.strobeOn && codeQ);
    rdStrobeN   = !(extQ && ctl.strobeOn && !codeQ && !writeQ);
    wrStrobeN   = !wrDrive;
  end

  assign romAddr   = addrQ[ROM_ADDR_W-1:0];
  assign doneValid = ctl.done;
  assign doneData  = rdataQ;
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int ROM_ADDR_W  = 12,
  parameter int CLKS_PER_MC = 12,
  parameter int LATCH_END   = 1,
  parameter int DATA_START  = 3,
  parameter int STROBE_END  = 10,
  parameter int SAMPLE_AT   = 10
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  input  logic                      reqCode,
  input  logic                      reqWrite,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [DATA_W-1:0]         reqWdata,
  input  logic                      extAccessN,
  output logic [ROM_ADDR_W-1:0]     romAddr,
  input  logic [DATA_W-1:0]         romRdata,
  output logic [DATA_W-1:0]         busLowOut,
  output logic                      busLowOe,
  input  logic [DATA_W-1:0]         busLowIn,
  output logic [ADDR_W-DATA_W-1:0]  busHigh,
  output logic                      latchStrobe,
  output logic                      progStrobeN,
  output logic                      rdStrobeN,
  output logic                      wrStrobeN,
  output logic                      doneValid,
  output logic [DATA_W-1:0]         doneData
);
  xbusCtl_t ctl;

  xbus_ctrl #(
    .CLKS_PER_MC(CLKS_PER_MC), .LATCH_END(LATCH_END), .DATA_START(DATA_START),
    .STROBE_END(STROBE_END), .SAMPLE_AT(SAMPLE_AT)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .ctl(ctl)
  );

  xbus_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROM_ADDR_W(ROM_ADDR_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .reqCode(reqCode), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .extAccessN(extAccessN),
    .romAddr(romAddr), .romRdata(romRdata),
    .busLowOut(busLowOut), .busLowOe(busLowOe), .busLowIn(busLowIn),
    .busHigh(busHigh), .latchStrobe(latchStrobe),
    .progStrobeN(progStrobeN), .rdStrobeN(rdStrobeN), .wrStrobeN(wrStrobeN),
    .doneValid(doneValid), .doneData(doneData)
  );
endmodule

// File: rtl/ext_bus_seq_checks.sv
module ext_bus_seq_checks #(
  parameter int DATA_W = 8,
  parameter int HI_W   = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] busLowOut,
  input logic              busLowOe,
  input logic [HI_W-1:0]   busHigh,
  input logic              latchStrobe,
  input logic              progStrobeN,
  input logic              rdStrobeN,
  input logic              wrStrobeN,
  input logic              doneValid
);
  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    $countones({!progStrobeN, !rdStrobeN, !wrStrobeN}) <= 1);

  p_latch_apart_r3: assert property (@(posedge clk) disable iff (!rstN)
    latchStrobe |-> (progStrobeN && rdStrobeN && wrStrobeN));

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(latchStrobe) |-> (busLowOe && $stable(busLowOut)));

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  p_done_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (progStrobeN && rdStrobeN && wrStrobeN && !latchStrobe));

  p_wr_drive_r6: assert property (@(posedge clk) disable iff (!rstN)
    !wrStrobeN |-> busLowOe);

  p_rd_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!rdStrobeN || !progStrobeN) |-> !busLowOe);

  p_high_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!rdStrobeN && $past(!rdStrobeN)) |-> $stable(busHigh));
endmodule

bind ext_bus_seq ext_bus_seq_checks #(.DATA_W(DATA_W), .HI_W(ADDR_W - DATA_W)) i_checks (
  .clk(clk), .rstN(rstN), .busLowOut(busLowOut), .busLowOe(busLowOe),
  .busHigh(busHigh), .latchStrobe(latchStrobe), .progStrobeN(progStrobeN),
  .rdStrobeN(rdStrobeN), .wrStrobeN(wrStrobeN), .doneValid(doneValid)
);

// File: tb/test_ext_bus_seq.sv
module test_ext_bus_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqCode, reqWrite, extAccessN;
  logic [15:0] reqAddr;
  logic [7:0]  reqWdata;
  logic [11:0] romAddr;
  logic [7:0]  romRdata, busLowOut, busLowIn, busHigh, doneData;
  logic        busLowOe, latchStrobe, progStrobeN, rdStrobeN, wrStrobeN, doneValid;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_bus_seq i_ext_bus_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCode(reqCode),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .extAccessN(extAccessN), .romAddr(romAddr), .romRdata(romRdata),
    .busLowOut(busLowOut), .busLowOe(busLowOe), .busLowIn(busLowIn),
    .busHigh(busHigh), .latchStrobe(latchStrobe), .progStrobeN(progStrobeN),
    .rdStrobeN(rdStrobeN), .wrStrobeN(wrStrobeN), .doneValid(doneValid),
    .doneData(doneData)
  );

  // Memory models: ROM byte from its address, external byte from the latched address.
  logic [7:0] latchLo = 8'h00;
  always @(negedge latchStrobe) latchLo = busLowOut;
  assign romRdata = romAddr[7:0] + {4'h0, romAddr[11:8]} + 8'h33;
  assign busLowIn = (!progStrobeN || !rdStrobeN) ? (latchLo ^ busHigh ^ 8'h5A) : 8'h00;

  // Packed observation: latch, oe, low, high, prog, rd, wr, done
  function automatic logic [21:0] observe();
    return {latchStrobe, busLowOe, busLowOut, busHigh, progStrobeN, rdStrobeN, wrStrobeN, doneValid};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] sweepAddr(input int i);
    case (i)
      0: return 16'h0000; 1: return 16'h0001; 2: return 16'h0FFE; 3: return 16'h0FFF;
      4: return 16'h1000; 5: return 16'h1001; 6: return 16'h7FA5; default: return 16'hFFFF;
    endcase
  endfunction

  task automatic runAccess(input logic code, input logic wr, input logic [15:0] addr,
                           input logic [7:0] wd, input logic extN, input string kindTag,
                           input bit inject);
    logic ext, dataWr;
    logic [7:0] expData;
    ext = !(code && extN && (addr < 16'h1000));
    dataWr = wr && !code;
    expData = ext ? (addr[7:0] ^ addr[15:8] ^ 8'h5A)
                  : (addr[7:0] + {4'h0, addr[11:8]} + 8'h33);
    @(negedge clk);
    reqValid = 1'b1; reqCode = code; reqWrite = wr; reqAddr = addr;
    reqWdata = wd; extAccessN = extN;
    @(negedge clk);
    reqValid = 1'b0;
    for (int p = 0; p < 12; p++) begin
      logic eLatch, eOe, eStr, eProg, eRd, eWr;
      logic [7:0] eLow, eHigh;
      string tag;
      eLatch = ext && (p <= 1);
      eStr = ext && (p >= 3) && (p <= 10);
      eOe = (ext && (p < 3)) || (eStr && dataWr);
      eLow = (ext && (p < 3)) ? addr[7:0] : ((eStr && dataWr) ? wd : 8'h00);
      eHigh = ext ? addr[15:8] : 8'h00;
      eProg = !(eStr && code);
      eRd = !(eStr && !code && !dataWr);
      eWr = !(eStr && dataWr);
      if (inject && p >= 5) tag = "R11";
      else if (p == 11) tag = "R2";
      else if (ext && p < 3) tag = "R3";
      else tag = kindTag;
      check(tag, {10'd0, observe()},
            {10'd0, eLatch, eOe, eLow, eHigh, eProg, eRd, eWr, (p == 11)});
      if (!ext) check("R7", {20'd0, romAddr}, {20'd0, addr[11:0]});
      if (p == 11 && !dataWr) check(ext ? "R5" : "R7", {24'd0, doneData}, {24'd0, expData});
      if (inject && p == 5) begin
        reqValid = 1'b1; reqCode = 1'b0; reqWrite = 1'b1;
        reqAddr = ~addr; reqWdata = ~wd; extAccessN = extN;
      end
      if (inject && p == 6) reqValid = 1'b0;
      @(negedge clk);
    end
    check(inject ? "R11" : "R2", {10'd0, observe()}, {10'd0, 22'b0_0_00000000_00000000_1_1_1_0});
    if (inject) begin
      @(negedge clk);
      check("R11", {10'd0, observe()}, {10'd0, 22'b0_0_00000000_00000000_1_1_1_0});
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqCode = 1'b0; reqWrite = 1'b0;
    reqAddr = '0; reqWdata = '0; extAccessN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", {10'd0, observe()}, {10'd0, 22'b0_0_00000000_00000000_1_1_1_0});
    rstN = 1'b1;
    @(negedge clk);
    check("R1", {10'd0, observe()}, {10'd0, 22'b0_0_00000000_00000000_1_1_1_0});
    for (int i = 0; i < 8; i++) begin
      logic [15:0] a;
      a = sweepAddr(i);
      runAccess(1'b1, 1'b0, a, 8'h00, 1'b1, (a < 16'h1000) ? "R7" : "R9", 0);
      runAccess(1'b1, 1'b0, a, 8'h00, 1'b0, "R8", 0);
      runAccess(1'b0, 1'b0, a, 8'h00, 1'b1, (a < 16'h1000) ? "R10" : "R5", 0);
      runAccess(1'b0, 1'b1, a, 8'hC3 ^ a[7:0], 1'b1, (a < 16'h1000) ? "R10" : "R6", 0);
      runAccess(1'b1, 1'b1, a, 8'hA5, 1'b0, "R4", 0);
    end
    runAccess(1'b0, 1'b0, 16'h2468, 8'h00, 1'b1, "R5", 1);
    runAccess(1'b1, 1'b0, 16'h0123, 8'h00, 1'b1, "R7", 1);
    runAccess(1'b0, 1'b1, 16'hBEEF, 8'h3C, 1'b1, "R6", 1);
    summary();
  end
endmodule